// File: doc/BRIEF.md
# Status-Driven Bus Command Controller

This block sits next to a processor that encodes the kind of each bus cycle on three status lines instead of driving its own strobes. The block watches those lines, opens a bus cycle when they leave the passive code, and walks the cycle through states T1, T2, T3, optional wait states and T4. In step with those states it produces the address latch pulse, the transceiver enable and direction, and separate active-low commands for memory and I/O reads and writes. It also produces early (advanced) write commands and an interrupt-acknowledge strobe.

A ready input stretches the cycle with wait states between T3 and T4. An address-enable input and a chip-enable input let a system with several bus masters take the commands off the bus. One dual-purpose output changes meaning with a strap. When the strap is low it enables the cascade of an interrupt controller. When the strap is high it enables peripheral data transfer. All outputs come from registers.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: Status codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write and 111 passive. A cycle starts only on a clock edge where the status is neither passive nor halt and the status at the previous edge was passive. The block accepts this only while idle or in T4. Halt, passive and a status held active after its cycle ends start nothing.
- R2: `ale` is high for exactly the T1 state of each cycle.
- R3: `dt_r` is low from T1 through T4 of interrupt-acknowledge, I/O read, code fetch and memory read cycles. It is high at all other times.
- R4: `den` is high from T2 through T4, wait states included, and is low at all other times.
- R5: Read commands are active low from T2 through T4. `mrd_n` serves codes 100 and 101, `iord_n` serves 001 and `inta_n` serves 000.
- R6: In a write cycle the advanced write (`amwr_n` for 110, `aiowr_n` for 010) is active from T2 through T4. The normal write (`mwr_n`, `iowr_n`) is active from T3 through T4.
- R7: A low `rdy` at the edge that ends T3 or a wait state adds one more wait state. `den`, `dt_r` and every active command hold their values through wait states.
- R8: While `aen_n` is high all seven commands are inactive. While `cen` is low the commands, `den` and `mce_pden` are inactive. `ale` and `dt_r` do not depend on these inputs.
- R9: With `iob` low, `mce_pden` is high only in T1 of an interrupt-acknowledge cycle. With `iob` high it is high from T2 through T4 of every cycle.
- R10: Two interrupt-acknowledge cycles in a row, the second starting from T4 of the first, give two separate low pulses on `inta_n`, with a high T1 between them.
- R11: Synchronous reset forces the idle state at once: `ale`, `den` and `mce_pden` low, `dt_r` high, all commands high, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat | input | 3 | Encoded cycle status from the processor |
| rdy | input | 1 | Ready; low at the end of T3 inserts wait states |
| aen_n | input | 1 | Address enable, active low; high disables commands |
| cen | input | 1 | Command enable, active high |
| iob | input | 1 | Strap selecting the role of `mce_pden` |
| ale | output | 1 | Address latch enable pulse |
| den | output | 1 | Data transceiver enable |
| dt_r | output | 1 | Transceiver direction, high = transmit |
| mce_pden | output | 1 | Cascade enable or peripheral data enable |
| inta_n | output | 1 | Interrupt acknowledge, active low |
| mrd_n | output | 1 | Memory read command, active low |
| mwr_n | output | 1 | Memory write command, active low |
| amwr_n | output | 1 | Advanced memory write command, active low |
| iord_n | output | 1 | I/O read command, active low |
| iowr_n | output | 1 | I/O write command, active low |
| aiowr_n | output | 1 | Advanced I/O write command, active low |

## Verification
The bench compares every output in every state of cycles with zero, one and two wait states. A design that samples ready in the wrong state would show commands dropping early or T4 arriving late. Runs with the enable inputs off and with the strap flipped catch commands that leak past the gating and a dual-purpose output driven in the wrong state. Directed cases cover halt, a status held active past its cycle, and a second acknowledge cycle opened from T4. They also cover reset during a write. A wrong design would restart cycles it should ignore, merge the two acknowledge pulses into one, or leave a write command asserted after reset.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int STAT_W = 3;
  localparam int PH_W   = 3;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4
  } phase_t;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA  = 3'b000,
    ST_IORD  = 3'b001,
    ST_IOWR  = 3'b010,
    ST_HALT  = 3'b011,
    ST_FETCH = 3'b100,
    ST_MRD   = 3'b101,
    ST_MWR   = 3'b110,
    ST_PASS  = 3'b111
  } stat_t;

  // internal command set, active high
  typedef struct packed {
    logic inta;
    logic mrd;
    logic mwr;
    logic amwr;
    logic iord;
    logic iowr;
    logic aiowr;
  } cmd_t;
endpackage

// File: rtl/bcc_start_det.sv
module bcc_start_det
  import bcc_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] stat,
  output logic          start,
  output stat_t         code
);
  logic [SW-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= ST_PASS;
    else     prev_q <= stat;
  end

  assign code  = stat_t'(stat);
  // R1: passive-to-active transition, halt excluded
  assign start = (prev_q == ST_PASS) && (code != ST_PASS) && (code != ST_HALT);
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  stat_t  code,
  input  logic   rdy,
  output phase_t phase_d,
  output stat_t  code_d
);
  phase_t phase_q;
  stat_t  code_q;

  always_comb begin
    phase_d = phase_q;
    code_d  = code_q;
    case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_T1;
        code_d  = code;
      end
      PH_T1: phase_d = PH_T2;
      PH_T2: phase_d = PH_T3;
      PH_T3, PH_TW: phase_d = rdy ? PH_T4 : PH_TW;
      PH_T4: begin
        if (start) begin
          phase_d = PH_T1;
          code_d  = code;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      code_q  <= ST_PASS;
    end else begin
      phase_q <= phase_d;
      code_q  <= code_d;
    end
  end
endmodule

// File: rtl/bcc_cmd_dec.sv
module bcc_cmd_dec
  import bcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  input  stat_t  code,
  input  logic   aen_n,
  input  logic   cen,
  input  logic   iob,
  output logic   ale,
  output logic   den,
  output logic   dt_r,
  output logic   mce_pden,
  output cmd_t   cmd
);
  logic in_cyc, data_ph, late_ph, is_rd, gate;
  logic ale_d, den_d, dtr_d, mp_d;
  cmd_t cmd_d;

  always_comb begin
    in_cyc  = (phase != PH_IDLE);
    data_ph = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);
    late_ph = (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);
    is_rd   = (code == ST_INTA) || (code == ST_IORD) || (code == ST_FETCH) || (code == ST_MRD);
    gate    = cen && !aen_n;

    ale_d = (phase == PH_T1);
    den_d = cen && data_ph;
    dtr_d = !(in_cyc && is_rd);
    mp_d  = cen && (iob ? data_ph : ((phase == PH_T1) && (code == ST_INTA)));

    cmd_d.inta  = gate && data_ph && (code == ST_INTA);
    cmd_d.mrd   = gate && data_ph && ((code == ST_MRD) || (code == ST_FETCH));
    cmd_d.iord  = gate && data_ph && (code == ST_IORD);
    cmd_d.amwr  = gate && data_ph && (code == ST_MWR);
    cmd_d.mwr   = gate && late_ph && (code == ST_MWR);
    cmd_d.aiowr = gate && data_ph && (code == ST_IOWR);
    cmd_d.iowr  = gate && late_ph && (code == ST_IOWR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale      <= 1'b0;
      den      <= 1'b0;
      dt_r     <= 1'b1;
      mce_pden <= 1'b0;
      cmd      <= '0;
    end else begin
      ale      <= ale_d;
      den      <= den_d;
      dt_r     <= dtr_d;
      mce_pden <= mp_d;
      cmd      <= cmd_d;
    end
  end
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] stat,
  input  logic          rdy,
  input  logic          aen_n,
  input  logic          cen,
  input  logic          iob,
  output logic          ale,
  output logic          den,
  output logic          dt_r,
  output logic          mce_pden,
  output logic          inta_n,
  output logic          mrd_n,
  output logic          mwr_n,
  output logic          amwr_n,
  output logic          iord_n,
  output logic          iowr_n,
  output logic          aiowr_n
);
  logic   start;
  stat_t  code;
  phase_t phase_d;
  stat_t  code_d;
  cmd_t   cmd;

  bcc_start_det #(.SW(SW)) u_det (
    .clk(clk), .rst(rst), .stat(stat), .start(start), .code(code)
  );

  bcc_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .code(code), .rdy(rdy),
    .phase_d(phase_d), .code_d(code_d)
  );

  bcc_cmd_dec u_dec (
    .clk(clk), .rst(rst), .phase(phase_d), .code(code_d),
    .aen_n(aen_n), .cen(cen), .iob(iob),
    .ale(ale), .den(den), .dt_r(dt_r), .mce_pden(mce_pden), .cmd(cmd)
  );

  assign inta_n  = ~cmd.inta;
  assign mrd_n   = ~cmd.mrd;
  assign mwr_n   = ~cmd.mwr;
  assign amwr_n  = ~cmd.amwr;
  assign iord_n  = ~cmd.iord;
  assign iowr_n  = ~cmd.iowr;
  assign aiowr_n = ~cmd.aiowr;
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
  input logic clk,
  input logic rst,
  input logic aen_n,
  input logic ale,
  input logic den,
  input logic dt_r,
  input logic inta_n,
  input logic mrd_n,
  input logic mwr_n,
  input logic amwr_n,
  input logic iord_n,
  input logic iowr_n,
  input logic aiowr_n
);
  logic [6:0] cmds_act;
  assign cmds_act = ~{inta_n, mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n};

  a_r2_ale_single: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);

  a_r5_one_command: assert property (@(posedge clk) disable iff (rst)
    $countones(cmds_act & 7'b1100100) <= 1 && $onehot0(cmds_act & 7'b1110110));

  a_r6_mem_adv_first: assert property (@(posedge clk) disable iff (rst) !mwr_n |-> !amwr_n);

  a_r6_io_adv_first: assert property (@(posedge clk) disable iff (rst) !iowr_n |-> !aiowr_n);

  a_r8_aen_gate: assert property (@(posedge clk) disable iff (rst)
    $past(aen_n) |-> (cmds_act == 7'b0));

  a_r3_dir_steady: assert property (@(posedge clk) disable iff (rst) den |-> $stable(dt_r));
endmodule

bind bus_cmd_ctrl bcc_checker u_chk (
  .clk(clk), .rst(rst), .aen_n(aen_n), .ale(ale), .den(den), .dt_r(dt_r),
  .inta_n(inta_n), .mrd_n(mrd_n), .mwr_n(mwr_n), .amwr_n(amwr_n),
  .iord_n(iord_n), .iowr_n(iowr_n), .aiowr_n(aiowr_n)
);

// File: tb/bus_cmd_ctrl_test.sv
module bus_cmd_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] stat = 3'b111;
  logic rdy = 1'b0, aen_n = 1'b0, cen = 1'b1, iob = 1'b0;
  logic ale, den, dt_r, mce_pden, inta_n, mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_cmd_ctrl uut (
    .clk(clk), .rst(rst), .stat(stat), .rdy(rdy), .aen_n(aen_n), .cen(cen), .iob(iob),
    .ale(ale), .den(den), .dt_r(dt_r), .mce_pden(mce_pden), .inta_n(inta_n),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .amwr_n(amwr_n), .iord_n(iord_n),
    .iowr_n(iowr_n), .aiowr_n(aiowr_n)
  );

  // {code[2:0], waits[2:0], aen_n, cen, iob}
  localparam int NV = 11;
  localparam logic [8:0] VEC [NV] = '{
    {3'b101, 3'd0, 1'b0, 1'b1, 1'b1},
    {3'b100, 3'd1, 1'b0, 1'b1, 1'b0},
    {3'b110, 3'd0, 1'b0, 1'b1, 1'b0},
    {3'b110, 3'd2, 1'b0, 1'b1, 1'b0},
    {3'b001, 3'd0, 1'b0, 1'b1, 1'b0},
    {3'b010, 3'd1, 1'b0, 1'b1, 1'b1},
    {3'b000, 3'd0, 1'b0, 1'b1, 1'b0},
    {3'b000, 3'd0, 1'b0, 1'b1, 1'b1},
    {3'b101, 3'd0, 1'b1, 1'b1, 1'b0},
    {3'b010, 3'd0, 1'b0, 1'b0, 1'b1},
    {3'b110, 3'd0, 1'b1, 1'b0, 1'b0}
  };

  localparam logic [10:0] IDLE_V = 11'b0010_1111111;

  // phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
  // vector: {ale, den, dt_r, mce_pden, inta_n, mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n}
  function automatic logic [10:0] model(input logic [2:0] c, input int ph,
                                        input logic a_n, input logic ce, input logic ib);
    logic act, dat, lat, rd, g;
    logic [6:0] cm;
    act = (ph != 0);
    dat = (ph >= 2);
    lat = (ph >= 3);
    rd  = (c == 3'b000) || (c == 3'b001) || (c == 3'b100) || (c == 3'b101);
    g   = ce && !a_n;
    cm[6] = g && dat && (c == 3'b000);
    cm[5] = g && dat && (c == 3'b100 || c == 3'b101);
    cm[4] = g && lat && (c == 3'b110);
    cm[3] = g && dat && (c == 3'b110);
    cm[2] = g && dat && (c == 3'b001);
    cm[1] = g && lat && (c == 3'b010);
    cm[0] = g && dat && (c == 3'b010);
    return {ph == 1, ce && dat, !(act && rd),
            ce && (ib ? dat : (ph == 1 && c == 3'b000)), ~cm};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [10:0] exp);
    logic [10:0] got;
    got = {ale, den, dt_r, mce_pden, inta_n, mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic run_cycle(input logic [2:0] c, input int waits, input string tag);
    stat = c; rdy = 1'b0;
    tick(); chk({tag, " T1 R2 R3"}, model(c, 1, aen_n, cen, iob));
    tick(); chk({tag, " T2 R4 R5 R6"}, model(c, 2, aen_n, cen, iob));
    stat = 3'b111;
    tick(); chk({tag, " T3 R6"}, model(c, 3, aen_n, cen, iob));
    rdy = (waits == 0);
    for (int i = 0; i < waits; i++) begin
      tick(); chk({tag, " wait R7"}, model(c, 4, aen_n, cen, iob));
      rdy = (i == waits - 1);
    end
    tick(); chk({tag, " T4 R5 R6"}, model(c, 5, aen_n, cen, iob));
    rdy = 1'b0;
    tick(); chk({tag, " end R1"}, model(c, 0, aen_n, cen, iob));
  endtask

  initial begin
    // R11 reset state
    repeat (3) tick();
    chk("R11 reset", IDLE_V);
    rst = 1'b0;
    tick(); chk("R1 idle passive", IDLE_V);

    for (int v = 0; v < NV; v++) begin
      {stat, rdy} = {3'b111, 1'b0};
      aen_n = VEC[v][2]; cen = VEC[v][1]; iob = VEC[v][0];
      tick();
      run_cycle(VEC[v][8:6], int'(VEC[v][5:3]), $sformatf("vec%0d R8 R9", v));
    end
    aen_n = 1'b0; cen = 1'b1; iob = 1'b0;

    // R1 halt starts nothing
    stat = 3'b011;
    tick(); chk("R1 halt", IDLE_V);
    tick(); chk("R1 halt", IDLE_V);
    stat = 3'b111; tick();

    // R1 status held active after its cycle: no restart
    stat = 3'b101;
    tick(); chk("R1 held T1", model(3'b101, 1, 1'b0, 1'b1, 1'b0));
    tick(); tick(); rdy = 1'b1;
    tick(); chk("R1 held T4", model(3'b101, 5, 1'b0, 1'b1, 1'b0));
    rdy = 1'b0;
    tick(); chk("R1 held no restart", IDLE_V);
    tick(); chk("R1 held no restart", IDLE_V);
    stat = 3'b111; tick();

    // R10 two acknowledge cycles, second opened from T4
    stat = 3'b000;
    tick(); chk("R10 first T1", model(3'b000, 1, 1'b0, 1'b1, 1'b0));
    tick(); chk("R10 first pulse", model(3'b000, 2, 1'b0, 1'b1, 1'b0));
    stat = 3'b111;
    tick(); rdy = 1'b1;
    tick(); chk("R10 first T4", model(3'b000, 5, 1'b0, 1'b1, 1'b0));
    stat = 3'b000; rdy = 1'b0;
    tick(); chk("R10 gap T1", model(3'b000, 1, 1'b0, 1'b1, 1'b0));
    tick(); chk("R10 second pulse", model(3'b000, 2, 1'b0, 1'b1, 1'b0));
    stat = 3'b111;
    tick(); rdy = 1'b1;
    tick(); rdy = 1'b0;
    tick(); chk("R10 end", IDLE_V);

    // R11 reset in the middle of a write
    stat = 3'b110;
    tick(); tick(); stat = 3'b111;
    tick(); chk("R6 write T3", model(3'b110, 3, 1'b0, 1'b1, 1'b0));
    rst = 1'b1;
    tick(); chk("R11 mid-cycle reset", IDLE_V);
    rst = 1'b0; rdy = 1'b1;
    tick(); chk("R11 stays idle", IDLE_V);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule